// File: doc/BRIEF.md
# Direct-Mapped Branch Direction Predictor

This block guesses whether a fetched conditional branch will be taken. It keeps a table of small saturating counters addressed by the low PC bits that sit just above the 4-byte instruction offset. The fetch stage presents a PC on the lookup port and receives a taken / not-taken guess combinationally in the same cycle. When the branch later resolves, the execute stage presents that branch's PC and its real direction on the update port, and the addressed counter moves one step toward that outcome.

Entries have no tag. Two branches whose index bits match share, and disturb, one counter. A parameter picks the entry width. With one bit, the entry simply remembers the last outcome. With two bits, the entry has hysteresis: a strongly biased entry must be wrong twice in a row before its guess reverses. On a loop branch this halves the mispredictions per loop exit.

Top module: `dirPredictTable`

## Requirements
- R1: The table index is PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). PC bits [1:0] and every bit above IDX_W+1 have no effect. PCs that differ only in those bits address the same entry.
- R2: predictTaken reflects the entry addressed by lookupPc in the same cycle, with no register between lookupPc and predictTaken.
- R3: After reset every entry predicts not-taken. A 2-bit entry holds 1 (weakly not-taken) and a 1-bit entry holds 0.
- R4: In 2-bit mode, a taken update adds 1 to the entry and a not-taken update subtracts 1. The count stays at 3 when it would rise above 3 and stays at 0 when it would fall below 0.
- R5: The prediction is the entry's most significant bit. In 2-bit mode, counts 2 and 3 predict taken and counts 0 and 1 predict not-taken.
- R6: In 2-bit mode, an entry at 3 still predicts taken after one not-taken update, and predicts not-taken after a second consecutive one.
- R7: In 1-bit mode, after any update the entry predicts exactly the outcome of that update.
- R8: While updateValid is low, no entry changes, whatever updatePc and updateTaken carry.
- R9: When an update and a lookup address the same entry in one cycle, the lookup returns the value from before that update. The new value is visible from the next cycle.
- R10: An update changes only the entry its PC addresses.
- R11: For a loop branch whose pattern repeats as nine taken then one not-taken, the 1-bit mode mispredicts twice per repetition. Once the 2-bit mode reaches steady state, it mispredicts once per repetition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | PC of the branch being fetched |
| predictTaken | output | 1 | Combinational guess: 1 = taken |
| updateValid | input | 1 | Qualifies the update port for this cycle |
| updatePc | input | PC_W | PC of the resolved branch |
| updateTaken | input | 1 | Real direction of the resolved branch: 1 = taken |

## Verification
A corrupted counter shows at the ports only when its entry is looked up. The bench therefore reads every entry of a 16-entry table after each update, so a wrong step, a missed saturation or a write to the wrong entry shows up within one update. Hysteresis faults, such as flipping after one miss or ignoring the saturation limit, appear only over sequences of updates. The bench drives runs of identical outcomes and loop patterns and counts mispredictions per loop repetition. The read-before-write rule is checked in the update cycle itself, while the lookup port points at the entry being written.

// File: rtl/dirPredPkg.sv
package dirPredPkg;
  // Strobes sent from the control to the counter datapath on each update
  typedef struct packed {
    logic stepUp;    // move addressed counter one step toward taken
    logic stepDown;  // move addressed counter one step toward not-taken
  } ctrlStrobes_t;
endpackage

// File: rtl/dirPredCtrl.sv
module dirPredCtrl
  import dirPredPkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             updValid,
  input  logic             updTaken,
  input  logic [CTR_W-1:0] updCount,
  output ctrlStrobes_t     strobes
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;
  localparam logic [CTR_W-1:0] CNT_MIN = '0;

  logic atMax;
  logic atMin;

  generate
    if (CTR_W == 1) begin : g_lastOutcome
      // A single bit is "at max" when it holds taken, so a step only rewrites it
      assign atMax = updCount[0];
      assign atMin = ~updCount[0];
    end else begin : g_hysteresis
      assign atMax = (updCount == CNT_MAX);
      assign atMin = (updCount == CNT_MIN);
    end
  endgenerate

  always_comb begin
    strobes.stepUp   = updValid &  updTaken & ~atMax;
    strobes.stepDown = updValid & ~updTaken & ~atMin;
  end
endmodule

// File: rtl/dirPredStore.sv
module dirPredStore
  import dirPredPkg::*;
#(
  parameter int ENTRIES = 1024,
  parameter int CTR_W   = 2,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdTaken,
  input  logic [IDX_W-1:0] updIdx,
  output logic [CTR_W-1:0] updCount,
  input  ctrlStrobes_t     strobes
);
  // Weakly not-taken for counters, not-taken for a single bit
  localparam logic [CTR_W-1:0] RST_VAL = (CTR_W == 1) ? CTR_W'(0) : CTR_W'(1);
  localparam logic [CTR_W-1:0] ONE     = CTR_W'(1);

  logic [CTR_W-1:0] cntArr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [CTR_W-1:0] cntQ;
    logic             hit;
    assign hit = (updIdx == IDX_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= RST_VAL;
      end else if (hit) begin
        if (strobes.stepUp)        cntQ <= cntQ + ONE;
        else if (strobes.stepDown) cntQ <= cntQ - ONE;
      end
    end
    assign cntArr[e] = cntQ;
  end

  // Combinational reads: the lookup sees the value stored before this edge
  assign rdTaken  = cntArr[rdIdx][CTR_W-1];
  assign updCount = cntArr[updIdx];
endmodule

// File: rtl/dirPredictTable.sv
module dirPredictTable
  import dirPredPkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 1024,
  parameter int CTR_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predictTaken,
  input  logic            updateValid,
  input  logic [PC_W-1:0] updatePc,
  input  logic            updateTaken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int IDX_LO = 2;                 // word-aligned instructions
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] lookupIdx;
  logic [IDX_W-1:0] updIdx;
  logic [CTR_W-1:0] updCount;
  ctrlStrobes_t     strobes;
  logic             unusedPcBits;

  assign lookupIdx    = lookupPc[IDX_HI:IDX_LO];
  assign updIdx       = updatePc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[IDX_LO-1:0],
                          updatePc[PC_W-1:IDX_HI+1], updatePc[IDX_LO-1:0]};

  dirPredCtrl #(.CTR_W(CTR_W)) u_ctrl (
    .updValid (updateValid),
    .updTaken (updateTaken),
    .updCount (updCount),
    .strobes  (strobes)
  );

  dirPredStore #(.ENTRIES(ENTRIES), .CTR_W(CTR_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .rdIdx    (lookupIdx),
    .rdTaken  (predictTaken),
    .updIdx   (updIdx),
    .updCount (updCount),
    .strobes  (strobes)
  );
endmodule

// File: rtl/dirPredChecker.sv
module dirPredChecker #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic            predictTaken,
  input logic            updateValid,
  input logic [PC_W-1:0] updatePc,
  input logic            updateTaken
);
  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] upIdx;
  logic             unusedChkBits;
  assign lkIdx = lookupPc[IDX_W+1:2];
  assign upIdx = updatePc[IDX_W+1:2];
  assign unusedChkBits = ^{lookupPc[PC_W-1:IDX_W+2], lookupPc[1:0],
                           updatePc[PC_W-1:IDX_W+2], updatePc[1:0]};

  // R4: a taken update never turns a taken guess into not-taken
  p_taken_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updateValid && updateTaken && upIdx == lkIdx && predictTaken)
      |=> (lkIdx != $past(lkIdx)) || predictTaken);

  // R4: a not-taken update never turns a not-taken guess into taken
  p_nottaken_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updateValid && !updateTaken && upIdx == lkIdx && !predictTaken)
      |=> (lkIdx != $past(lkIdx)) || !predictTaken);

  // R8: with no valid update the looked-up entry keeps its guess
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !updateValid |=> (lkIdx != $past(lkIdx)) || $stable(predictTaken));

  // R10: an update to another entry leaves the looked-up entry alone
  p_other_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    (updateValid && upIdx != lkIdx)
      |=> (lkIdx != $past(lkIdx)) || $stable(predictTaken));

  generate
    if (CTR_W == 1) begin : g_oneBit
      // R7: a 1-bit entry predicts the last outcome written to it
      p_last_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
        (updateValid && upIdx == lkIdx)
          |=> (lkIdx != $past(lkIdx)) || (predictTaken == $past(updateTaken)));
    end
  endgenerate
endmodule

bind dirPredictTable dirPredChecker #(
  .PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)
) u_dirPredChecker (
  .clk          (clk),
  .rstN         (rstN),
  .lookupPc     (lookupPc),
  .predictTaken (predictTaken),
  .updateValid  (updateValid),
  .updatePc     (updatePc),
  .updateTaken  (updateTaken)
);

// File: tb/test_dirPredictTable.sv
module test_dirPredictTable;
  localparam int PC_W = 12;
  localparam int ENTRIES = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic [PC_W-1:0] updatePc = '0;
  logic updateValid = 1'b0;
  logic updateTaken = 1'b0;
  logic pred2;
  logic pred1;

  int vectors = 0;
  int fails = 0;
  int m2 [ENTRIES];
  int m1 [ENTRIES];
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  dirPredictTable #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_W(2)) i_dirPredictTable (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(pred2),
    .updateValid(updateValid), .updatePc(updatePc), .updateTaken(updateTaken));

  dirPredictTable #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_W(1)) i_dirPredictTable1 (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predictTaken(pred1),
    .updateValid(updateValid), .updatePc(updatePc), .updateTaken(updateTaken));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] mkPc(input int idx, input logic [15:0] salt);
    return {salt[PC_W-IDX_W-3:0], idx[IDX_W-1:0], salt[15:14]};
  endfunction

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Bench model of one update, applied at the edge
  task automatic modelUpd(input int idx, input logic t);
    if (t) m2[idx] = (m2[idx] == 3) ? 3 : m2[idx] + 1;
    else   m2[idx] = (m2[idx] == 0) ? 0 : m2[idx] - 1;
    m1[idx] = t ? 1 : 0;
  endtask

  // Update one entry, looking up the same entry in the same cycle (R9)
  task automatic doUpdate(input int idx, input logic t, input logic [15:0] salt);
    @(negedge clk);
    updateValid = 1'b1;
    updateTaken = t;
    updatePc = mkPc(idx, salt);
    lookupPc = mkPc(idx, ~salt);
    #1;
    chk("R9 2-bit read before write", pred2, m2[idx] >= 2);
    chk("R9 1-bit read before write", pred1, m1[idx]);
    @(posedge clk);
    modelUpd(idx, t);
    @(negedge clk);
    updateValid = 1'b0;
  endtask

  task automatic lookOne(input string req, input int idx, input logic [15:0] salt);
    @(negedge clk);
    updateValid = 1'b0;
    lookupPc = mkPc(idx, salt);
    #1;
    chk({req, " 2-bit"}, pred2, m2[idx] >= 2);
    chk({req, " 1-bit"}, pred1, m1[idx]);
  endtask

  task automatic sweepAll(input string req);
    for (int i = 0; i < ENTRIES; i++) begin
      stepLfsr();
      lookOne(req, i, lfsr);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int mis1;
    int mis2;
    logic [PC_W-1:0] keepPc;
    for (int i = 0; i < ENTRIES; i++) begin
      m2[i] = 1;
      m1[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R3: every entry guesses not-taken after reset (R2 combinational read)
    sweepAll("R3 reset state R2");

    // R4 R5 R10 R1: pseudo-random updates with varied upper and low PC bits
    for (int n = 0; n < 160; n++) begin
      stepLfsr();
      doUpdate(int'(lfsr[3:0]), lfsr[7] | lfsr[9], lfsr);
      sweepAll("R4 R5 R10 R1 random sweep");
    end

    // R8: update port carries data but updateValid is low
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      stepLfsr();
      updateValid = 1'b0;
      updatePc = mkPc(n, lfsr);
      updateTaken = ~(m2[n] >= 2);
      @(posedge clk);
    end
    sweepAll("R8 invalid update ignored");

    // R6: saturate entry 5 at 3, then two consecutive not-taken updates
    for (int n = 0; n < 4; n++) doUpdate(5, 1'b1, 16'h1234);
    lookOne("R6 saturated taken", 5, 16'h0F0F);
    doUpdate(5, 1'b0, 16'h4321);
    @(negedge clk);
    lookupPc = mkPc(5, 16'h5555);
    #1;
    chk("R6 one miss keeps taken", pred2, 1);
    chk("R7 one-bit follows miss", pred1, 0);
    doUpdate(5, 1'b0, 16'hAAAA);
    @(negedge clk);
    lookupPc = mkPc(5, 16'h00F0);
    #1;
    chk("R6 second miss flips", pred2, 0);

    // R1: aliasing PCs that differ only above the index share one entry
    keepPc = mkPc(9, 16'h0000);
    doUpdate(9, 1'b1, 16'h0000);
    doUpdate(9, 1'b1, 16'hFFFF);
    @(negedge clk);
    lookupPc = keepPc;
    #1;
    chk("R1 aliased entry shared", pred2, m2[9] >= 2);

    // R11: loop pattern nine taken, one not-taken, five repetitions on entry 7
    for (int v = 0; v < 5; v++) begin
      mis1 = 0;
      mis2 = 0;
      for (int k = 0; k < 10; k++) begin
        logic t;
        t = (k < 9);
        @(negedge clk);
        lookupPc = mkPc(7, 16'h0303);
        #1;
        if (pred2 != t) mis2++;
        if (pred1 != t) mis1++;
        doUpdate(7, t, 16'h0303);
      end
      if (v > 0) begin
        chk("R11 1-bit misses per visit", mis1, 2);
        chk("R11 2-bit misses per visit", mis2, 1);
      end
    end
    sweepAll("R10 final sweep");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule